// File: doc/BRIEF.md
# Debug Event Detect and Dispatch Controller

This block sits beside the retire stage of a processor core. It watches for two kinds of debug event and decides how the core responds to each one.

- **Tool request.** An external debug tool raises a request line. The block edge-detects it, so a level held for many cycles counts as one event. No enable gates it.
- **Instruction-value match.** Each valid retiring 32-bit instruction word goes through a masked compare against a programmed pattern.

Every event sets a sticky status bit. If debug interrupts are disabled when the event arrives, the block also sets an imprecise flag. Software clears the status with a write-one-to-clear port.

The response is chosen in a fixed order:

1. In external debug mode, when the action code decodes to stop, the block halts the core.
2. Otherwise, in internal debug mode, the block raises a debug interrupt at once if interrupts are enabled. If they are disabled, it holds the interrupt back until they become enabled. By then the status must still be uncleared.

The saved return address depends on the event:

- A value match saves the address of the matching instruction.
- A tool request saves the next-instruction address.
- A deferred interrupt saves the next-instruction address at the moment it is taken.

The dispatcher is a three-state machine:

- **RUN.** Normal execution.
  - RUN -> HALT is taken on any event while external mode is set and the action code is stop.
  - RUN -> SERVICE is taken when internal mode and interrupt enable are both set and there is either a new event or a pending status bit. This transition emits a one-cycle interrupt pulse.
  - Halt has priority over the interrupt.
- **HALT.** The stop request is held. HALT is left only by reset.
- **SERVICE.** An interrupt has been delivered. SERVICE -> RUN is taken once the interrupt enable is seen low, which marks the handler running with interrupts masked. No further interrupt is raised while in SERVICE.

Top module: `dbg_event_ctrl`

## Requirements
- R1: A rising edge on `tool_req` is one tool event and sets status bit 0 on the next clock edge, with no enable. A request held high yields only one event.
- R2: A value-match event occurs only when `ret_valid` and `cmp_en` are both 1 and `(ret_insn & cmp_mask) == (cmp_value & cmp_mask)`. It sets status bit 1. Without a valid retire, without the enable, or on a masked mismatch, nothing happens.
- R3: Any event that occurs while `int_en` is 0 also sets status bit 2, the imprecise flag.
- R4: A clock edge with `clr_wr` = 1 clears every status bit that has a 1 in `clr_mask`. When a bit is set and cleared in the same cycle, it stays set.
- R5: An event with `ext_mode` = 1 and `act_code` = 2'b01 raises `stop_req` on the next edge. `stop_req` then stays high until reset. `ret_addr` is `ret_pc` for a value match and `next_pc` for a tool event.
- R6: In external mode, an action code other than 2'b01 does not stop the core. The internal-mode bit then decides whether an interrupt follows.
- R7: An event with `int_mode` = 1 and `int_en` = 1 produces a one-cycle `irq_req` pulse on the next edge. `ret_addr` is `ret_pc` for a value match and `next_pc` for a tool event.
- R8: An event with `int_mode` = 1 and `int_en` = 0 raises no interrupt. The interrupt is raised later, on the edge after `int_en` is 1, with `ret_addr` = `next_pc` of that cycle. This happens only if status bit 0 or bit 1 is still set.
- R9: After an interrupt, no further interrupt is raised until `int_en` has been sampled 0.
- R10: When both events occur in the same cycle, both status bits are set and `ret_addr` takes `ret_pc`.
- R11: After reset, `status`, `stop_req`, `irq_req` and `ret_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tool_req | input | 1 | Debug tool event request (level, edge-detected) |
| ret_valid | input | 1 | A retiring instruction is present this cycle |
| ret_insn | input | 32 | Retiring instruction word |
| ret_pc | input | 32 | Address of the retiring instruction |
| next_pc | input | 32 | Address of the next instruction to execute |
| cmp_en | input | 1 | Value-compare event enable |
| cmp_value | input | 32 | Value-compare pattern |
| cmp_mask | input | 32 | Value-compare bit mask (1 = compared) |
| ext_mode | input | 1 | External debug mode |
| act_code | input | 2 | External debug action, 2'b01 = stop |
| int_mode | input | 1 | Internal debug mode |
| int_en | input | 1 | Debug interrupt enable |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | 3 | Status bits to clear (1 = clear) |
| stop_req | output | 1 | Core stop request |
| irq_req | output | 1 | Debug interrupt pulse |
| ret_addr | output | 32 | Saved return / stop address |
| status | output | 3 | Status: bit0 tool, bit1 value match, bit2 imprecise |

## Verification
The compare is exercised with three patterns:
- a word that matches only once unmasked bits are ignored, which shows the mask is honoured;
- a word differing in a single masked bit, which shows the compare is not a plain equality on a subset;
- a matching word without the valid strobe or without the enable, which shows that both gate the event.

For dispatch, each event kind is tried under stop, non-stop external, immediate-internal and deferred-internal settings. Comparing `ret_addr` against the two address inputs tells the event kinds apart. The deferred cases contrast a status left set with a status cleared beforehand. A held request and a same-cycle set-and-clear probe the edge detector and the set-wins rule.

// File: rtl/dbg_event_pkg.sv
package dbg_event_pkg;
    localparam int INSN_W = 32;
    localparam int ADDR_W = 32;
    localparam int ACT_W  = 2;
    localparam int STAT_W = 3;

    localparam int ST_TOOL = 0;
    localparam int ST_VAL  = 1;
    localparam int ST_IMP  = 2;

    typedef enum logic [1:0] {
        S_RUN     = 2'd0,
        S_HALT    = 2'd1,
        S_SERVICE = 2'd2
    } dbg_state_e;
endpackage

// File: rtl/dbg_req_edge.sv
module dbg_req_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic pulse
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    assign pulse = req & ~req_q;

    assert_single_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/dbg_value_match.sv
module dbg_value_match #(
    parameter int W = 32
) (
    input  logic         valid,
    input  logic         enable,
    input  logic [W-1:0] insn,
    input  logic [W-1:0] pattern,
    input  logic [W-1:0] mask,
    output logic         hit
);
    logic [W-1:0] diff;

    assign diff = (insn ^ pattern) & mask;
    assign hit  = valid & enable & (diff == '0);
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_eff) | set;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);
        assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_eff[i] && !set[i]) |=> !q[i]);
    end
endmodule

// File: rtl/dbg_event_ctrl.sv
module dbg_event_ctrl
    import dbg_event_pkg::*;
#(
    parameter int               IW       = INSN_W,
    parameter int               AW       = ADDR_W,
    parameter int               AC_W     = ACT_W,
    parameter logic [AC_W-1:0]  ACT_STOP = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tool_req,
    input  logic              ret_valid,
    input  logic [IW-1:0]     ret_insn,
    input  logic [AW-1:0]     ret_pc,
    input  logic [AW-1:0]     next_pc,
    input  logic              cmp_en,
    input  logic [IW-1:0]     cmp_value,
    input  logic [IW-1:0]     cmp_mask,
    input  logic              ext_mode,
    input  logic [AC_W-1:0]   act_code,
    input  logic              int_mode,
    input  logic              int_en,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_mask,
    output logic              stop_req,
    output logic              irq_req,
    output logic [AW-1:0]     ret_addr,
    output logic [STAT_W-1:0] status
);
    logic              ev_tool, ev_val, any_ev, pending;
    logic [STAT_W-1:0] stat_set;
    logic [AW-1:0]     ev_addr;
    logic              go_halt, go_irq;
    dbg_state_e        state, state_n;

    dbg_req_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (tool_req),
        .pulse (ev_tool)
    );

    dbg_value_match #(.W(IW)) u_match (
        .valid   (ret_valid),
        .enable  (cmp_en),
        .insn    (ret_insn),
        .pattern (cmp_value),
        .mask    (cmp_mask),
        .hit     (ev_val)
    );

    assign any_ev             = ev_tool | ev_val;
    assign stat_set[ST_TOOL]  = ev_tool;
    assign stat_set[ST_VAL]   = ev_val;
    assign stat_set[ST_IMP]   = any_ev & ~int_en;

    dbg_status_reg #(.W(STAT_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (stat_set),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .q        (status)
    );

    // A pending event is one whose status bit survives this cycle's clear
    assign pending = (status[ST_TOOL] & ~(clr_wr & clr_mask[ST_TOOL]))
                   | (status[ST_VAL]  & ~(clr_wr & clr_mask[ST_VAL]));

    // Value match wins the saved address when both events coincide
    assign ev_addr = ev_val ? ret_pc : next_pc;

    // Next-state logic
    always_comb begin
        state_n = state;
        go_halt = 1'b0;
        go_irq  = 1'b0;
        unique case (state)
            S_RUN: begin
                if (any_ev && ext_mode && (act_code == ACT_STOP)) begin
                    go_halt = 1'b1;
                    state_n = S_HALT;
                end else if (int_mode && int_en && (any_ev || pending)) begin
                    go_irq  = 1'b1;
                    state_n = S_SERVICE;
                end
            end
            S_HALT: state_n = S_HALT;
            S_SERVICE: if (!int_en) state_n = S_RUN;
            default: state_n = S_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_RUN;
        else        state <= state_n;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req  <= 1'b0;
            ret_addr <= '0;
        end else begin
            irq_req <= go_irq;
            if (go_halt || go_irq) ret_addr <= ev_addr;
        end
    end

    assign stop_req = (state == S_HALT);

    assert_halt_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> stop_req);
    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);
    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(int_mode && int_en));
    assert_masked_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |=> !irq_req);
    assert_val_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_val && int_mode && int_en && state == S_RUN && !ext_mode) |=> (ret_addr == $past(ret_pc)));
    assert_imprecise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (any_ev && !int_en) |=> status[ST_IMP]);
endmodule

// File: tb/dbg_event_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_event_ctrl_bench;
    localparam logic [31:0] PAT   = 32'h7C00_02A6;
    localparam logic [31:0] MSK   = 32'hFC00_07FE;
    localparam logic [31:0] HIT   = 32'h7C21_02A6;
    localparam logic [31:0] MISS  = 32'h7C00_02A4;
    localparam logic [31:0] RPC   = 32'h0000_1000;
    localparam logic [31:0] NPC   = 32'h0000_1004;

    typedef struct packed {
        logic        tool;
        logic        vld;
        logic [31:0] insn;
        logic        en;
        logic        xm;
        logic [1:0]  act;
        logic        im;
        logic        ie;
        logic [2:0]  e_st;
        logic        e_stop;
        logic        e_irq;
        logic [31:0] e_ret;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 3'b001, 1'b1, 1'b0, NPC},   // R1 R5 tool stop
        '{1'b0, 1'b1, HIT,   1'b1, 1'b1, 2'b01, 1'b0, 1'b1, 3'b010, 1'b1, 1'b0, RPC},   // R2 R5 value stop
        '{1'b0, 1'b1, HIT,   1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0, 32'h0}, // R2 disabled
        '{1'b0, 1'b1, MISS,  1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0, 32'h0}, // R2 masked mismatch
        '{1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 3'b001, 1'b0, 1'b1, NPC},   // R7 tool irq
        '{1'b0, 1'b1, HIT,   1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 3'b010, 1'b0, 1'b1, RPC},   // R7 value irq
        '{1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 3'b001, 1'b0, 1'b1, NPC},   // R6 no stop, irq
        '{1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1, 3'b001, 1'b0, 1'b0, 32'h0}, // R6 no stop, no irq
        '{1'b1, 1'b1, HIT,   1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 3'b011, 1'b0, 1'b1, RPC},   // R10 both
        '{1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 3'b101, 1'b0, 1'b0, 32'h0}, // R3 R8 deferred
        '{1'b0, 1'b0, HIT,   1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0, 32'h0}  // R2 no valid
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tool_req, ret_valid, cmp_en, ext_mode, int_mode, int_en, clr_wr;
    logic [31:0] ret_insn, ret_pc, next_pc, cmp_value, cmp_mask;
    logic [1:0]  act_code;
    logic [2:0]  clr_mask;
    logic        stop_req, irq_req;
    logic [31:0] ret_addr;
    logic [2:0]  status;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dbg_event_ctrl u_dbg_event_ctrl (
        .clk(clk), .rst_n(rst_n), .tool_req(tool_req), .ret_valid(ret_valid),
        .ret_insn(ret_insn), .ret_pc(ret_pc), .next_pc(next_pc), .cmp_en(cmp_en),
        .cmp_value(cmp_value), .cmp_mask(cmp_mask), .ext_mode(ext_mode),
        .act_code(act_code), .int_mode(int_mode), .int_en(int_en), .clr_wr(clr_wr),
        .clr_mask(clr_mask), .stop_req(stop_req), .irq_req(irq_req),
        .ret_addr(ret_addr), .status(status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tool_req = 0; ret_valid = 0; ret_insn = '0; cmp_en = 0;
        ext_mode = 0; act_code = 2'b00; int_mode = 0; int_en = 0;
        clr_wr = 0; clr_mask = '0;
        ret_pc = RPC; next_pc = NPC; cmp_value = PAT; cmp_mask = MSK;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0;
        idle_inputs();
        do_reset();
        step();
        check("R11 status", {29'b0, status}, 32'h0);
        check("R11 stop", {31'b0, stop_req}, 32'h0);
        check("R11 irq", {31'b0, irq_req}, 32'h0);
        check("R11 ret", ret_addr, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            tool_req = VECS[i].tool; ret_valid = VECS[i].vld; ret_insn = VECS[i].insn;
            cmp_en = VECS[i].en; ext_mode = VECS[i].xm; act_code = VECS[i].act;
            int_mode = VECS[i].im; int_en = VECS[i].ie;
            step();
            check($sformatf("R1/R2/R3/R10 vec%0d status", i), {29'b0, status}, {29'b0, VECS[i].e_st});
            check($sformatf("R5/R6 vec%0d stop", i), {31'b0, stop_req}, {31'b0, VECS[i].e_stop});
            check($sformatf("R7/R8 vec%0d irq", i), {31'b0, irq_req}, {31'b0, VECS[i].e_irq});
            check($sformatf("R5/R7 vec%0d ret", i), ret_addr, VECS[i].e_ret);
        end

        // R5: halt persists
        do_reset();
        tool_req = 1; ext_mode = 1; act_code = 2'b01;
        step();
        @(negedge clk); idle_inputs();
        for (int k = 0; k < 4; k++) step();
        check("R5 stop held", {31'b0, stop_req}, 32'h1);

        // R1: held request gives one event
        do_reset();
        int_mode = 1; int_en = 1; tool_req = 1;
        step();
        check("R1 held first irq", {31'b0, irq_req}, 32'h1);
        @(negedge clk); int_en = 0; clr_wr = 1; clr_mask = 3'b111;
        step();
        @(negedge clk); clr_wr = 0;
        step(); step();
        check("R1 held no re-event", {29'b0, status}, 32'h0);

        // R8, R9: deferred interrupt, then no repeat until enable seen low
        do_reset();
        int_mode = 1; tool_req = 1;
        step();
        check("R3 imprecise", {29'b0, status}, 32'h5);
        @(negedge clk); tool_req = 0; next_pc = 32'h0000_2000;
        step();
        check("R8 held back", {31'b0, irq_req}, 32'h0);
        @(negedge clk); int_en = 1;
        step();
        check("R8 delayed irq", {31'b0, irq_req}, 32'h1);
        check("R8 delayed ret", ret_addr, 32'h0000_2000);
        step();
        check("R9 no repeat", {31'b0, irq_req}, 32'h0);
        step();
        check("R9 no repeat later", {31'b0, irq_req}, 32'h0);
        @(negedge clk); int_en = 0;
        @(negedge clk); int_en = 1;
        step();
        check("R9 re-arm irq", {31'b0, irq_req}, 32'h1);

        // R8, R4: cleared before enable gives no interrupt
        do_reset();
        int_mode = 1; tool_req = 1;
        step();
        @(negedge clk); tool_req = 0; clr_wr = 1; clr_mask = 3'b011;
        step();
        check("R4 clear", {29'b0, status}, 32'h4);
        @(negedge clk); clr_wr = 0; int_en = 1;
        step();
        check("R8 cleared no irq", {31'b0, irq_req}, 32'h0);

        // R4: set wins over clear in the same cycle
        do_reset();
        tool_req = 1;
        step();
        @(negedge clk); tool_req = 0;
        step();
        @(negedge clk); tool_req = 1; clr_wr = 1; clr_mask = 3'b001;
        step();
        check("R4 set wins", {29'b0, status}, 32'h5);
        @(negedge clk); tool_req = 0; clr_mask = 3'b101;
        step();
        check("R4 clear after", {29'b0, status}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule